// File: doc/BRIEF.md
# Sub-clock idle wake-up release controller

This block decides when a processor leaves its sub-clock idle standby state and how it resumes. Software parks the core with a one-cycle entry strobe that also says whether the idle is the normal or the low-voltage variant. The controller parks the PLL and then watches a non-maskable interrupt, a parameterised set of prioritised interrupt lines and a set of reset sources. Each interrupt source has its own standby mask bit.

An unmasked interrupt does not end idle at once. The wake is latched and a sub-clock counter runs first. When the counter expires, the block pulses a release strobe and gives the resume mode, the restored PLL command and a verdict. The verdict is either a branch to the handler, or a continue at the next instruction with the request left pending. A reset source cuts any wait short and asks for the ordinary reset sequence on the next cycle.

The verdict depends on the interrupt-enable state, on whether idle was entered inside a handler and on the priority of that handler. The block runs entirely on the sub-clock.

Top module: `wk_release_ctrl`

## Requirements
- R1: While idle, an unmasked NMI (`nmi_i`=1, `nmi_mask_i`=0) or any unmasked line (`irq_i[k]`=1, `irq_mask_i[k]`=0) starts a release, whatever its priority.
- R2: A source whose mask bit is 1 does not end idle: `idle_o` stays 1 and `release_o` stays 0.
- R3: `release_o` is a one-cycle pulse. It first reads 1 in the cycle after the REL_DLY-th rising edge that follows the edge at which the wake was sampled, and not earlier.
- R4: The wake is latched when it is sampled, so a request that drops during the wait still completes the release.
- R5: With several unmasked lines, the verdict uses the one of highest priority. A larger `irq_prio_i` field value means higher priority when PRIO_LOW_WINS=0. Line k owns bits [k*PRIO_W +: PRIO_W].
- R6: Idle entered inside a handler (`in_handler_i`=1) with interrupts enabled gives the following verdicts. A winning line of strictly higher priority than `cur_prio_i` gives `branch_o`=1, `pend_o`=0. An equal or lower one gives `branch_o`=0, `pend_o`=1. An NMI always gives `branch_o`=1, `pend_o`=0.
- R7: Outside a handler, `int_en_i`=1 gives `branch_o`=1. `int_en_i`=0 gives `branch_o`=0 and `pend_o`=1, meaning execution continues at the next instruction.
- R8: On an interrupt release, `resume_mode_o` is 1 (sub-clock mode) after normal idle and 2 (low-voltage sub-clock mode) after low-voltage idle.
- R9: `pll_run_o` is 0 throughout idle. A release from normal idle restores the value it had at entry. A release from low-voltage idle leaves it at 0 until software writes it again.
- R10: A nonzero `rst_src_i` while idle or waiting gives, on the next cycle, `release_o`=1 and `reset_req_o`=1 with `resume_mode_o`=0, `branch_o`=0, `pend_o`=0 and `pll_run_o`=0. It takes precedence over a wake in the same cycle and abandons any running count.
- R11: `pll_wr_i` loads `pll_wdata_i` into `pll_run_o` only outside idle. A write during idle is ignored.
- R12: After `rst_n` the block is running, not idle (`idle_o`=0), with `release_o`=0, `resume_mode_o`=0 and `pll_run_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| idle_enter_i | input | 1 | Entry strobe into sub-clock idle |
| idle_lowv_i | input | 1 | With the entry strobe: 1 selects low-voltage idle |
| pll_wr_i | input | 1 | Software PLL command write |
| pll_wdata_i | input | 1 | PLL command value (1 = run) |
| nmi_i | input | 1 | Non-maskable interrupt request |
| nmi_mask_i | input | 1 | 1 blocks the NMI from ending idle |
| irq_i | input | N_IRQ | Maskable interrupt request lines |
| irq_mask_i | input | N_IRQ | Per-line standby release mask (1 = masked) |
| irq_prio_i | input | N_IRQ*PRIO_W | Packed per-line priorities |
| in_handler_i | input | 1 | Idle was entered inside a handler |
| cur_prio_i | input | PRIO_W | Priority of the handler in service |
| int_en_i | input | 1 | Global interrupt enable |
| rst_src_i | input | N_RST | Reset sources (pin, watchdog, voltage detector, clock monitor) |
| idle_o | output | 1 | Core is in idle or in the release wait |
| release_o | output | 1 | One-cycle release strobe |
| reset_req_o | output | 1 | With release: run the reset sequence |
| resume_mode_o | output | 2 | 0 main/reset, 1 sub-clock, 2 low-voltage sub-clock |
| pll_run_o | output | 1 | PLL command (1 = run) |
| branch_o | output | 1 | Release verdict: branch to handler |
| pend_o | output | 1 | Release verdict: request not acknowledged, stays pending |

## Verification
The bench builds the block with N_IRQ=8, PRIO_W=3, REL_DLY=12 and PRIO_LOW_WINS=0. With 8 lines, a low-priority and a high-priority line can be raised together, so the winner selection is exercised. With 3-bit priorities, handler levels strictly below, equal to and above the winner all fit. REL_DLY=12 keeps the latency check exact while leaving room to inject a reset in the middle of the count.

// File: rtl/wk_pkg.sv
package wk_pkg;

   typedef enum logic [1:0] {
      RM_MAIN  = 2'd0,
      RM_SUB   = 2'd1,
      RM_LVSUB = 2'd2
   } resume_mode_e;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_IDLE = 2'd1,
      ST_WAIT = 2'd2
   } wk_state_e;

   localparam int unsigned PRIO_MAX_W = 8;

   // true when priority a outranks priority b
   function automatic logic prio_above(input logic [PRIO_MAX_W-1:0] a,
                                       input logic [PRIO_MAX_W-1:0] b,
                                       input logic low_wins);
      return low_wins ? (a < b) : (a > b);
   endfunction

endpackage

// File: rtl/wk_detect.sv
module wk_detect #(
   parameter int unsigned N_IRQ         = 8,
   parameter int unsigned PRIO_W        = 3,
   parameter bit          PRIO_LOW_WINS = 1'b0
) (
   input  logic [N_IRQ-1:0]        irq_i,
   input  logic [N_IRQ-1:0]        irq_mask_i,
   input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
   input  logic                    nmi_i,
   input  logic                    nmi_mask_i,
   output logic                    nmi_hit_o,
   output logic                    irq_hit_o,
   output logic [PRIO_W-1:0]       win_prio_o
);
   import wk_pkg::*;

   logic [N_IRQ-1:0]  live;
   logic [PRIO_W-1:0] prio_arr [N_IRQ];

   for (genvar g = 0; g < N_IRQ; g++) begin : g_line
      assign live[g]     = irq_i[g] & ~irq_mask_i[g];
      assign prio_arr[g] = irq_prio_i[g*PRIO_W +: PRIO_W];
   end

   always_comb begin
      logic              found;
      logic [PRIO_W-1:0] best;
      found = 1'b0;
      best  = '0;
      for (int i = 0; i < N_IRQ; i++) begin
         if (live[i] && (!found ||
             prio_above(PRIO_MAX_W'(prio_arr[i]), PRIO_MAX_W'(best), PRIO_LOW_WINS))) begin
            found = 1'b1;
            best  = prio_arr[i];
         end
      end
      irq_hit_o  = found;
      win_prio_o = best;
   end

   assign nmi_hit_o = nmi_i & ~nmi_mask_i;

endmodule

// File: rtl/wk_decide.sv
module wk_decide #(
   parameter int unsigned PRIO_W        = 3,
   parameter bit          PRIO_LOW_WINS = 1'b0
) (
   input  logic              nmi_hit_i,
   input  logic [PRIO_W-1:0] win_prio_i,
   input  logic              in_handler_i,
   input  logic [PRIO_W-1:0] cur_prio_i,
   input  logic              int_en_i,
   output logic              branch_o
);
   logic outranks;

   if (PRIO_LOW_WINS) begin : g_low_wins
      assign outranks = (win_prio_i < cur_prio_i);
   end else begin : g_high_wins
      assign outranks = (win_prio_i > cur_prio_i);
   end

   assign branch_o = nmi_hit_i | (int_en_i & (~in_handler_i | outranks));

endmodule

// File: rtl/wk_delay.sv
module wk_delay #(
   parameter int unsigned DLY = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic abort_i,
   output logic done_o
);
   localparam int unsigned CW = (DLY > 2) ? $clog2(DLY) : 1;
   localparam logic [CW-1:0] LAST = CW'(DLY - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (abort_i) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign done_o = busy_q && (cnt_q == LAST) && !abort_i;

endmodule

// File: rtl/wk_release_ctrl.sv
module wk_release_ctrl #(
   parameter int unsigned N_IRQ         = 8,
   parameter int unsigned PRIO_W        = 3,
   parameter int unsigned N_RST         = 4,
   parameter int unsigned REL_DLY       = 12,
   parameter bit          PRIO_LOW_WINS = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    idle_enter_i,
   input  logic                    idle_lowv_i,
   input  logic                    pll_wr_i,
   input  logic                    pll_wdata_i,
   input  logic                    nmi_i,
   input  logic                    nmi_mask_i,
   input  logic [N_IRQ-1:0]        irq_i,
   input  logic [N_IRQ-1:0]        irq_mask_i,
   input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
   input  logic                    in_handler_i,
   input  logic [PRIO_W-1:0]       cur_prio_i,
   input  logic                    int_en_i,
   input  logic [N_RST-1:0]        rst_src_i,
   output logic                    idle_o,
   output logic                    release_o,
   output logic                    reset_req_o,
   output logic [1:0]              resume_mode_o,
   output logic                    pll_run_o,
   output logic                    branch_o,
   output logic                    pend_o
);
   import wk_pkg::*;

   if (N_IRQ < 1) begin : g_bad_nirq
      $error("wk_release_ctrl: N_IRQ must be at least 1");
   end
   if (PRIO_W < 1 || PRIO_W > PRIO_MAX_W) begin : g_bad_prio
      $error("wk_release_ctrl: PRIO_W out of range");
   end
   if (REL_DLY < 2) begin : g_bad_dly
      $error("wk_release_ctrl: REL_DLY must be at least 2");
   end
   if (N_RST < 1) begin : g_bad_rst
      $error("wk_release_ctrl: N_RST must be at least 1");
   end

   wk_state_e    st_q;
   resume_mode_e mode_q;
   logic         lowv_q, pll_q, pll_save_q;
   logic         rel_q, rstreq_q, br_q, pend_q, dec_br_q;

   logic              nmi_hit, irq_hit, wake_hit, any_rst, dec_br, dly_done;
   logic [PRIO_W-1:0] win_prio;
   logic              in_idle, in_wait, dly_start;

   wk_detect #(
      .N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .PRIO_LOW_WINS(PRIO_LOW_WINS)
   ) u_detect (
      .irq_i      (irq_i),
      .irq_mask_i (irq_mask_i),
      .irq_prio_i (irq_prio_i),
      .nmi_i      (nmi_i),
      .nmi_mask_i (nmi_mask_i),
      .nmi_hit_o  (nmi_hit),
      .irq_hit_o  (irq_hit),
      .win_prio_o (win_prio)
   );

   wk_decide #(
      .PRIO_W(PRIO_W), .PRIO_LOW_WINS(PRIO_LOW_WINS)
   ) u_decide (
      .nmi_hit_i    (nmi_hit),
      .win_prio_i   (win_prio),
      .in_handler_i (in_handler_i),
      .cur_prio_i   (cur_prio_i),
      .int_en_i     (int_en_i),
      .branch_o     (dec_br)
   );

   assign wake_hit  = nmi_hit | irq_hit;
   assign any_rst   = |rst_src_i;
   assign in_idle   = (st_q == ST_IDLE);
   assign in_wait   = (st_q == ST_WAIT);
   assign dly_start = in_idle && wake_hit && !any_rst;

   wk_delay #(.DLY(REL_DLY)) u_delay (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (dly_start),
      .abort_i (any_rst),
      .done_o  (dly_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_RUN;
         mode_q     <= RM_MAIN;
         lowv_q     <= 1'b0;
         pll_q      <= 1'b0;
         pll_save_q <= 1'b0;
         rel_q      <= 1'b0;
         rstreq_q   <= 1'b0;
         br_q       <= 1'b0;
         pend_q     <= 1'b0;
         dec_br_q   <= 1'b0;
      end else begin
         rel_q    <= 1'b0;
         rstreq_q <= 1'b0;
         if (st_q != ST_RUN && any_rst) begin
            st_q     <= ST_RUN;
            rel_q    <= 1'b1;
            rstreq_q <= 1'b1;
            mode_q   <= RM_MAIN;
            br_q     <= 1'b0;
            pend_q   <= 1'b0;
            pll_q    <= 1'b0;
            lowv_q   <= 1'b0;
         end else begin
            unique case (st_q)
               ST_RUN: begin
                  if (idle_enter_i) begin
                     st_q       <= ST_IDLE;
                     lowv_q     <= idle_lowv_i;
                     pll_save_q <= pll_q;
                     pll_q      <= 1'b0;
                  end else if (pll_wr_i) begin
                     pll_q <= pll_wdata_i;
                  end
               end
               ST_IDLE: begin
                  if (wake_hit) begin
                     st_q     <= ST_WAIT;
                     dec_br_q <= dec_br;
                  end
               end
               ST_WAIT: begin
                  if (dly_done) begin
                     st_q   <= ST_RUN;
                     rel_q  <= 1'b1;
                     br_q   <= dec_br_q;
                     pend_q <= ~dec_br_q;
                     mode_q <= lowv_q ? RM_LVSUB : RM_SUB;
                     pll_q  <= lowv_q ? 1'b0 : pll_save_q;
                  end
               end
               default: st_q <= ST_RUN;
            endcase
         end
      end
   end

   assign idle_o        = (st_q != ST_RUN);
   assign release_o     = rel_q;
   assign reset_req_o   = rstreq_q;
   assign resume_mode_o = mode_q;
   assign pll_run_o     = pll_q;
   assign branch_o      = br_q;
   assign pend_o        = pend_q;

endmodule

// File: rtl/wk_release_chk.sv
module wk_release_chk #(
   parameter int unsigned N_RST   = 4,
   parameter int unsigned REL_DLY = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_idle,
   input logic             in_wait,
   input logic             wake_hit,
   input logic [N_RST-1:0] rst_src_i,
   input logic             idle_o,
   input logic             release_o,
   input logic             reset_req_o,
   input logic [1:0]       resume_mode_o,
   input logic             pll_run_o,
   input logic             branch_o,
   input logic             pend_o
);
   localparam int unsigned CW = $clog2(REL_DLY + 2);

   logic [CW-1:0] wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wcnt <= '0;
      else if (in_wait) wcnt <= wcnt + 1'b1;
      else              wcnt <= '0;
   end

   AST_WAKE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_idle && wake_hit && rst_src_i == '0) |=> in_wait);  // R1
   AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_idle && !wake_hit && rst_src_i == '0) |=> (in_idle && !release_o));  // R2
   AST_RELEASE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (release_o && !reset_req_o) |-> (wcnt == CW'(REL_DLY)));  // R3
   AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      release_o |=> !release_o);  // R3
   AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (release_o && !reset_req_o) |-> (branch_o != pend_o));  // R6
   AST_IDLE_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o |-> !pll_run_o);  // R9
   AST_LV_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (release_o && resume_mode_o == 2'd2) |-> !pll_run_o);  // R9
   AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && rst_src_i != '0) |=> (release_o && reset_req_o));  // R10
   AST_RESET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req_o |-> (resume_mode_o == 2'd0 && !branch_o && !pend_o && !pll_run_o));  // R10

endmodule

bind wk_release_ctrl wk_release_chk #(
   .N_RST(N_RST), .REL_DLY(REL_DLY)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_idle       (in_idle),
   .in_wait       (in_wait),
   .wake_hit      (wake_hit),
   .rst_src_i     (rst_src_i),
   .idle_o        (idle_o),
   .release_o     (release_o),
   .reset_req_o   (reset_req_o),
   .resume_mode_o (resume_mode_o),
   .pll_run_o     (pll_run_o),
   .branch_o      (branch_o),
   .pend_o        (pend_o)
);

// File: tb/wk_release_ctrl_tb_top.sv
module wk_release_ctrl_tb_top;
   localparam int N_IRQ = 8, PRIO_W = 3, N_RST = 4, REL_DLY = 12;

   typedef struct {
      logic [1:0] mode;
      logic       br, pend, rr, pll;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic idle_enter_i = 0, idle_lowv_i = 0, pll_wr_i = 0, pll_wdata_i = 0;
   logic nmi_i = 0, nmi_mask_i = 0, in_handler_i = 0, int_en_i = 0;
   logic [N_IRQ-1:0] irq_i = '0, irq_mask_i = '0;
   logic [N_IRQ*PRIO_W-1:0] irq_prio_i = '0;
   logic [PRIO_W-1:0] cur_prio_i = '0;
   logic [N_RST-1:0] rst_src_i = '0;
   logic idle_o, release_o, reset_req_o, pll_run_o, branch_o, pend_o;
   logic [1:0] resume_mode_o;

   int n_cmp = 0, n_bad = 0;
   exp_t sb[$];
   logic pll_exp = 1'b0;

   always #2 clk = ~clk;

   wk_release_ctrl #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .N_RST(N_RST), .REL_DLY(REL_DLY)) dut_i (
      .clk(clk), .rst_n(rst_n), .idle_enter_i(idle_enter_i), .idle_lowv_i(idle_lowv_i),
      .pll_wr_i(pll_wr_i), .pll_wdata_i(pll_wdata_i), .nmi_i(nmi_i), .nmi_mask_i(nmi_mask_i),
      .irq_i(irq_i), .irq_mask_i(irq_mask_i), .irq_prio_i(irq_prio_i),
      .in_handler_i(in_handler_i), .cur_prio_i(cur_prio_i), .int_en_i(int_en_i),
      .rst_src_i(rst_src_i), .idle_o(idle_o), .release_o(release_o), .reset_req_o(reset_req_o),
      .resume_mode_o(resume_mode_o), .pll_run_o(pll_run_o), .branch_o(branch_o), .pend_o(pend_o));

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per release strobe
   always @(negedge clk) begin
      if (rst_n && release_o) begin
         if (sb.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2/R3 unexpected release actual=1 expected=0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk("R8 resume_mode", 8'(resume_mode_o), 8'(e.mode));
            chk("R6/R7 branch", 8'(branch_o), 8'(e.br));
            chk("R6/R7 pend", 8'(pend_o), 8'(e.pend));
            chk("R10 reset_req", 8'(reset_req_o), 8'(e.rr));
            chk("R9 pll_run", 8'(pll_run_o), 8'(e.pll));
         end
      end
   end

   task automatic enter_idle(logic lv);
      @(negedge clk); idle_enter_i = 1; idle_lowv_i = lv;
      @(negedge clk); idle_enter_i = 0; idle_lowv_i = 0;
   endtask

   task automatic pll_write(logic v);
      @(negedge clk); pll_wr_i = 1; pll_wdata_i = v;
      @(negedge clk); pll_wr_i = 0;
   endtask

   // drive a wake, drop it early (R4), check exact latency (R3)
   task automatic wake(logic nmi, logic [N_IRQ-1:0] lines, logic hnd, logic [PRIO_W-1:0] cur,
                       logic ie, exp_t e);
      @(negedge clk);
      nmi_i = nmi; irq_i = lines; in_handler_i = hnd; cur_prio_i = cur; int_en_i = ie;
      sb.push_back(e);
      for (int j = 1; j <= REL_DLY + 1; j++) begin
         @(posedge clk); #1;
         if (j == 2) begin nmi_i = 0; irq_i = '0; end
         if (j == REL_DLY) chk("R3 no early release", 8'(release_o), 8'd0);
         if (j == REL_DLY + 1) chk("R3 R4 release on time", 8'(release_o), 8'd1);
      end
      @(negedge clk);
      in_handler_i = 0; int_en_i = 0; cur_prio_i = '0;
   endtask

   function automatic exp_t mk(logic [1:0] m, logic br, logic rr, logic pll);
      exp_t e;
      e.mode = m; e.br = br; e.pend = ~br & ~rr; e.rr = rr; e.pll = pll;
      return e;
   endfunction

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      // priorities: line k gets k (line 2 = 2, line 4 = 4, line 6 = 6)
      for (int k = 0; k < N_IRQ; k++) irq_prio_i[k*PRIO_W +: PRIO_W] = PRIO_W'(k);
      repeat (3) @(negedge clk);
      chk("R12 idle after reset", 8'(idle_o), 8'd0);
      chk("R12 release after reset", 8'(release_o), 8'd0);
      chk("R12 mode after reset", 8'(resume_mode_o), 8'd0);
      chk("R12 pll after reset", 8'(pll_run_o), 8'd0);
      rst_n = 1;

      pll_write(1'b1); pll_exp = 1;
      chk("R11 pll write in run", 8'(pll_run_o), 8'd1);

      // R1 R7 R9: normal idle, not in handler, interrupts enabled
      enter_idle(1'b0);
      chk("R9 pll off in idle", 8'(pll_run_o), 8'd0);
      wake(0, 8'h08, 0, 0, 1, mk(2'd1, 1, 0, pll_exp));

      // R2: masked line and masked NMI do not wake
      enter_idle(1'b0);
      @(negedge clk); irq_mask_i = 8'h02; irq_i = 8'h02; nmi_mask_i = 1; nmi_i = 1;
      repeat (20) @(negedge clk);
      chk("R2 still idle", 8'(idle_o), 8'd1);
      irq_i = '0; nmi_i = 0; irq_mask_i = '0; nmi_mask_i = 0;
      // R11: write during idle is ignored; R9 restore on normal release
      pll_write(1'b0);
      chk("R11 pll write ignored in idle", 8'(pll_run_o), 8'd0);
      wake(0, 8'h01, 0, 0, 1, mk(2'd1, 1, 0, 1'b1));
      chk("R11 R9 restored after ignored write", 8'(pll_run_o), 8'd1);

      // R6 R8 R9: low-voltage idle in handler, lower priority line -> pending
      enter_idle(1'b1);
      wake(0, 8'h04, 1, 3'd4, 1, mk(2'd2, 0, 0, 0));
      repeat (5) @(negedge clk);
      chk("R9 pll stays off after lv release", 8'(pll_run_o), 8'd0);
      pll_write(1'b1);

      // R6: higher priority than handler -> acknowledged
      enter_idle(1'b0);
      wake(0, 8'h40, 1, 3'd4, 1, mk(2'd1, 1, 0, 1));
      // R6: equal priority -> not acknowledged
      enter_idle(1'b0);
      wake(0, 8'h10, 1, 3'd4, 1, mk(2'd1, 0, 0, 1));
      // R5: lines 2 and 6 together, handler 4 -> line 6 wins
      enter_idle(1'b0);
      wake(0, 8'h44, 1, 3'd4, 1, mk(2'd1, 1, 0, 1));
      // R7: interrupts disabled outside handler -> next instruction
      enter_idle(1'b0);
      wake(0, 8'h20, 0, 0, 0, mk(2'd1, 0, 0, 1));
      // R6 R1: NMI in handler with interrupts disabled -> branch
      enter_idle(1'b1);
      wake(1, 8'h00, 1, 3'd7, 0, mk(2'd2, 1, 0, 0));
      pll_write(1'b1);

      // R10: reset during the wait wins and abandons the count
      enter_idle(1'b0);
      @(negedge clk); irq_i = 8'h08; int_en_i = 1;
      repeat (5) @(negedge clk);
      irq_i = '0; rst_src_i = 4'b0010;
      sb.push_back(mk(2'd0, 0, 1, 0));
      @(posedge clk); #1;
      chk("R10 reset release next cycle", 8'(release_o), 8'd1);
      chk("R10 reset request", 8'(reset_req_o), 8'd1);
      @(negedge clk); rst_src_i = '0; int_en_i = 0;
      repeat (20) @(negedge clk);
      chk("R10 no late interrupt release", 8'(idle_o), 8'd0);

      // R10: reset from plain idle (clock monitor source)
      enter_idle(1'b1);
      @(negedge clk); rst_src_i = 4'b1000;
      sb.push_back(mk(2'd0, 0, 1, 0));
      @(negedge clk); rst_src_i = '0;
      repeat (4) @(negedge clk);
      chk("R10 scoreboard drained", 8'(sb.size()), 8'd0);
      finish_run();
   end
endmodule